// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is the control and status register that steers programming and bulk erase of an on-chip flash array. It also holds the address and data latch for one program operation. Software reaches the register through a byte-wide bus. The same bus carries the ordinary writes into the flash address window.

The block watches four inputs:
- a programming-voltage detector,
- a boot-protect configuration bit,
- a flag saying that interrupt vectors live in flash,
- the chip's wait-mode signal.

From the register state it produces a gated flash clock enable, an erase select with a boot-block erase qualifier, and a high-voltage enable toward the array. It also drives the captured program address and data.

Writes to the register pass through interlocks:
- The mode bits cannot change while high voltage is enabled.
- Arming the latch is refused without programming voltage.
- The clock-stop bit is refused while vectors live in flash.

Once the latch is armed, the first array write is captured and held for the program sequence.

Top module: `flash_pe_ctrl`

## Requirements
- R1: The register byte reads as follows: bits 7..5 always 0, bit 4 wait clock-stop, bit 3 voltage status, bit 2 erase select, bit 1 latch arm, bit 0 high-voltage enable. Bits 4, 2, 1 and 0 reset to 0, and the register can be read at any time.
- R2: Bit 3 is read-only. It mirrors `vppHigh` (1 means programming voltage is present), and writes to it have no effect.
- R3: Writes to bits 2 and 1 take effect only while bit 0 is 0. While bit 0 is 1, those bits keep their values.
- R4: A write that would set bit 1 from 0 is refused when `vppHigh` is 0.
- R5: While bit 1 is 1 and no capture is held, the next write whose address lies in [ARRAY_LO, ARRAY_HI] loads its address into `latchAddr`, loads its data into `latchData`, and sets `latchValid`. Writes outside that window are not captured.
- R6: Once `latchValid` is 1, further array writes leave `latchAddr` and `latchData` unchanged until bit 1 is cleared and armed again.
- R7: Clearing bit 1 drops `latchValid` at the same clock edge.
- R8: `hvEnable` is 1 only when bit 0, bit 1 and `latchValid` are all 1.
- R9: `eraseMode` equals bit 2. `eraseBoot` is 1 only when bit 2 is 1 and `bootProtect` is 0.
- R10: `flashClkEn` is 0 exactly when `waitMode` is 1 and bit 4 is 1. Otherwise it is 1.
- R11: A write that would set bit 4 is refused while `vectorsInFlash` is 1. Clearing bit 4 is always allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Write strobe for the current bus address |
| busAddr | input | AW | Bus address |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Register readback |
| vppHigh | input | 1 | Programming-voltage detector, 1 = present |
| bootProtect | input | 1 | 1 = boot block excluded from bulk erase |
| vectorsInFlash | input | 1 | 1 = interrupt vectors reside in flash |
| waitMode | input | 1 | Chip is in wait mode |
| flashClkEn | output | 1 | Flash clock enable |
| eraseMode | output | 1 | 1 = erase, 0 = program |
| eraseBoot | output | 1 | Bulk erase includes the boot block |
| hvEnable | output | 1 | High-voltage enable to the array |
| latchValid | output | 1 | A program capture is held |
| latchAddr | output | AW | Captured program address |
| latchData | output | 8 | Captured program data |

## Verification
The hardest state to reach is a write that hits the mode bits while high voltage is already enabled. Getting there needs the whole chain first: programming voltage present, latch armed, one array write captured, then the enable bit set.

The bench walks that chain in order. It then tries writes that would flip erase select and drop the latch arm, and reads back an unchanged register.

A second pass clears the enable bit, then the latch, and re-arms. This shows that a fresh capture replaces the old one, while a second array write in the same arming is ignored.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  // Bit positions in the control byte (software depends on them)
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_LATCH = 1;
  localparam int unsigned BIT_ERASE = 2;
  localparam int unsigned BIT_VSTAT = 3;
  localparam int unsigned BIT_WSTOP = 4;

  typedef struct packed {
    logic waitStop;
    logic eraseSel;
    logic latchArm;
    logic hvEn;
  } ctrl_reg_t;

  // Strobes from control to the latch datapath
  typedef struct packed {
    logic capture;
    logic clearValid;
  } latch_strobe_t;

endpackage

// File: rtl/flash_pe_regctl.sv
module flash_pe_regctl
  import flash_pe_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] REG_ADDR = 16'h00F7,
  parameter logic [AW-1:0] ARRAY_LO = 16'h8000,
  parameter logic [AW-1:0] ARRAY_HI = 16'hBFFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [7:0]    busWdata,
  input  logic          vppHigh,
  input  logic          vectorsInFlash,
  input  logic          capValid,
  output ctrl_reg_t     ctrlQ,
  output latch_strobe_t strobes
);

  logic regHit;
  logic arrayHit;
  ctrl_reg_t ctrlD;
  logic unusedWdata;

  assign regHit      = busWrite && (busAddr == REG_ADDR);
  assign arrayHit    = busWrite && (busAddr >= ARRAY_LO) && (busAddr <= ARRAY_HI);
  assign unusedWdata = ^{busWdata[7:5], busWdata[BIT_VSTAT]};

  always_comb begin
    ctrlD = ctrlQ;
    if (regHit) begin
      // Clock-stop may always be cleared, but set only when vectors are not in flash
      ctrlD.waitStop = busWdata[BIT_WSTOP] && !vectorsInFlash;
      ctrlD.hvEn     = busWdata[BIT_EN];
      // Mode bits are frozen while high voltage is enabled
      if (!ctrlQ.hvEn) begin
        ctrlD.eraseSel = busWdata[BIT_ERASE];
        ctrlD.latchArm = busWdata[BIT_LATCH] && (ctrlQ.latchArm || vppHigh);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlD;
  end

  assign strobes.capture    = arrayHit && ctrlQ.latchArm && !capValid;
  assign strobes.clearValid = !ctrlD.latchArm;

endmodule

// File: rtl/flash_pe_latch.sv
module flash_pe_latch
  import flash_pe_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  latch_strobe_t strobes,
  input  logic [AW-1:0] busAddr,
  input  logic [7:0]    busWdata,
  output logic          capValid,
  output logic [AW-1:0] capAddr,
  output logic [7:0]    capData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capAddr  <= '0;
      capData  <= '0;
    end else if (strobes.clearValid) begin
      capValid <= 1'b0;
    end else if (strobes.capture) begin
      capValid <= 1'b1;
      capAddr  <= busAddr;
      capData  <= busWdata;
    end
  end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] REG_ADDR = 16'h00F7,
  parameter logic [AW-1:0] ARRAY_LO = 16'h8000,
  parameter logic [AW-1:0] ARRAY_HI = 16'hBFFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [7:0]    busWdata,
  output logic [7:0]    busRdata,
  input  logic          vppHigh,
  input  logic          bootProtect,
  input  logic          vectorsInFlash,
  input  logic          waitMode,
  output logic          flashClkEn,
  output logic          eraseMode,
  output logic          eraseBoot,
  output logic          hvEnable,
  output logic          latchValid,
  output logic [AW-1:0] latchAddr,
  output logic [7:0]    latchData
);

  ctrl_reg_t     ctrlQ;
  latch_strobe_t strobes;

  flash_pe_regctl #(
    .AW(AW), .REG_ADDR(REG_ADDR), .ARRAY_LO(ARRAY_LO), .ARRAY_HI(ARRAY_HI)
  ) u_regctl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .vppHigh(vppHigh), .vectorsInFlash(vectorsInFlash),
    .capValid(latchValid), .ctrlQ(ctrlQ), .strobes(strobes)
  );

  flash_pe_latch #(.AW(AW)) u_latch (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .capValid(latchValid), .capAddr(latchAddr),
    .capData(latchData)
  );

  assign busRdata   = {3'b000, ctrlQ.waitStop, vppHigh, ctrlQ.eraseSel,
                       ctrlQ.latchArm, ctrlQ.hvEn};
  assign flashClkEn = !(waitMode && ctrlQ.waitStop);
  assign eraseMode  = ctrlQ.eraseSel;
  assign eraseBoot  = ctrlQ.eraseSel && !bootProtect;
  assign hvEnable   = ctrlQ.hvEn && ctrlQ.latchArm && latchValid;

endmodule

// File: rtl/flash_pe_checker.sv
module flash_pe_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic [7:0]    busRdata,
  input logic          vppHigh,
  input logic          vectorsInFlash,
  input logic          waitMode,
  input logic          flashClkEn,
  input logic          hvEnable,
  input logic          latchValid,
  input logic [AW-1:0] latchAddr,
  input logic [7:0]    latchData
);

  // R3: mode bits frozen while enable is set
  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[0] |=> (busRdata[2:1] == $past(busRdata[2:1])));

  // R4: latch arm cannot rise without programming voltage
  p_latch_refused_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdata[1] && !vppHigh) |=> !busRdata[1]);

  // R6: held capture stays put while armed
  p_capture_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (latchValid && busRdata[1]) |=> ($stable(latchAddr) && $stable(latchData)));

  // R7: no valid capture without the latch armed
  p_valid_needs_arm_r7: assert property (@(posedge clk) disable iff (!rstN)
    latchValid |-> busRdata[1]);

  // R8: high voltage only with arm, enable and capture
  p_hv_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    hvEnable |-> (busRdata[0] && busRdata[1] && latchValid));

  // R10: clock halted in wait mode when clock-stop is set
  p_clk_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (waitMode && busRdata[4]) |-> !flashClkEn);

  // R11: clock-stop cannot rise while vectors live in flash
  p_wstop_blocked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdata[4] && vectorsInFlash) |=> !busRdata[4]);

endmodule

bind flash_pe_ctrl flash_pe_checker #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .busRdata(busRdata), .vppHigh(vppHigh),
  .vectorsInFlash(vectorsInFlash), .waitMode(waitMode), .flashClkEn(flashClkEn),
  .hvEnable(hvEnable), .latchValid(latchValid), .latchAddr(latchAddr),
  .latchData(latchData)
);

// File: tb/flash_pe_ctrl_test.sv
`timescale 1ns/1ps
module flash_pe_ctrl_test;

  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] REG = 16'h00F7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic vppHigh = 1'b0, bootProtect = 1'b0, vectorsInFlash = 1'b0, waitMode = 1'b0;
  logic flashClkEn, eraseMode, eraseBoot, hvEnable, latchValid;
  logic [AW-1:0] latchAddr;
  logic [7:0] latchData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_pe_ctrl uut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .vppHigh(vppHigh),
    .bootProtect(bootProtect), .vectorsInFlash(vectorsInFlash),
    .waitMode(waitMode), .flashClkEn(flashClkEn), .eraseMode(eraseMode),
    .eraseBoot(eraseBoot), .hvEnable(hvEnable), .latchValid(latchValid),
    .latchAddr(latchAddr), .latchData(latchData)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset readback", busRdata, 8'h00);
    check("R9 reset erase", {eraseMode, eraseBoot}, 0);
    check("R8 reset hv", hvEnable, 0);
    check("R10 reset clock", flashClkEn, 1);
    busWr(REG, 8'hE0);
    check("R1 upper bits zero", busRdata, 8'h00);
  endtask

  task automatic t_status;
    vppHigh = 1'b1; #1;
    check("R2 status mirrors high", busRdata, 8'h08);
    vppHigh = 1'b0;
    busWr(REG, 8'h08);
    check("R2 status write ignored", busRdata, 8'h00);
  endtask

  task automatic t_latch_refuse;
    busWr(REG, 8'h02);
    check("R4 arm refused", busRdata, 8'h00);
    vppHigh = 1'b1;
    busWr(REG, 8'h02);
    check("R4 arm accepted", busRdata, 8'h0A);
  endtask

  task automatic t_capture;
    busWr(16'h1234, 8'hEE);
    check("R5 outside window", latchValid, 0);
    busWr(16'h9000, 8'h5A);
    check("R5 valid", latchValid, 1);
    check("R5 addr", latchAddr, 16'h9000);
    check("R5 data", latchData, 8'h5A);
    busWr(16'hA000, 8'h33);
    check("R6 second addr", latchAddr, 16'h9000);
    check("R6 second data", latchData, 8'h5A);
  endtask

  task automatic t_freeze;
    busWr(REG, 8'h03);
    check("R8 hv on", hvEnable, 1);
    busWr(REG, 8'h05);
    check("R3 frozen", busRdata, 8'h0B);
    busWr(REG, 8'h00);
    check("R3 frozen on disable", busRdata, 8'h0A);
    check("R8 hv off", hvEnable, 0);
    busWr(REG, 8'h00);
    check("R7 valid drops", latchValid, 0);
    busWr(REG, 8'h01);
    check("R8 no hv without arm", hvEnable, 0);
    busWr(REG, 8'h00);
    busWr(REG, 8'h02);
    busWr(16'hB000, 8'h77);
    check("R6 rearm capture addr", latchAddr, 16'hB000);
    check("R6 rearm capture data", latchData, 8'h77);
    busWr(REG, 8'h00);
  endtask

  task automatic t_erase;
    bootProtect = 1'b0;
    busWr(REG, 8'h04);
    check("R9 erase mode", eraseMode, 1);
    check("R9 boot included", eraseBoot, 1);
    bootProtect = 1'b1; #1;
    check("R9 boot protected", eraseBoot, 0);
    busWr(REG, 8'h00);
    check("R9 program mode", eraseMode, 0);
  endtask

  task automatic t_clock;
    vectorsInFlash = 1'b1;
    busWr(REG, 8'h10);
    check("R11 stop refused", busRdata[4], 0);
    vectorsInFlash = 1'b0;
    busWr(REG, 8'h10);
    check("R11 stop accepted", busRdata[4], 1);
    check("R10 running outside wait", flashClkEn, 1);
    waitMode = 1'b1; #1;
    check("R10 halted in wait", flashClkEn, 0);
    vectorsInFlash = 1'b1;
    busWr(REG, 8'h00);
    check("R11 clear allowed", busRdata[4], 0);
    check("R10 running with stop off", flashClkEn, 1);
    waitMode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_latch_refuse();
    t_capture();
    t_freeze();
    t_erase();
    t_clock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule